// File: doc/BRIEF.md
# Single-Cycle Register Processor with Delayed Memory Load

This block is a compact single-cycle processor core together with its data memory. Seven 8-bit signed registers form the register bank; one of them is the program counter, so the fetch address is read straight out of that register. Each cycle the core presents the program counter on an instruction-address port and takes back a 24-bit instruction word combinationally from an external instruction store. It decodes that word, evaluates a five-function ALU, updates the bank and steps or redirects the program counter.

The 32-word data memory lives inside the block. Its read port is synchronous: a load drives the read address in its own cycle, and the data appears one cycle later. To match this, the destination of a load is held in a register for one cycle, and the returning word is written to the bank at the end of the following cycle. There is no interlock. A program must place another instruction, such as a Nop, between a load and the first instruction that reads the loaded register. The memory read and write ports are brought out so that stores and read data can be observed.

Top module: `micro_core`

## Requirements
- R1: While rst_n is low at a clock edge, every register, the held load destination and all 32 memory words are cleared. After release, execution starts at address 0 and mem_rdata reads 0 until a load returns data.
- R2: An instruction word has its opcode in bits [23:21], the ALU function in [20:18], operand x in [17:15], operand y in [14:12], the destination in [11:9] and an 8-bit immediate in [7:0]; a memory address uses immediate bits [4:0]. Opcodes are 0 Nop, 1 Compute, 2 Branch, 3 Jump, 4 Load and 5 Store. Codes 6 and 7 act as Nop: no write, and the PC advances by 1.
- R3: The ALU function codes are 0 add, 1 subtract, 2 increment x, 3 pass x and 4 signed greater-than, which gives 1 or 0. Codes 5 to 7 pass x. Add and subtract wrap modulo 256.
- R4: Register indices are 0 Zero, 1 PC, 2 A, 3 B, 4 C, 5 D and 6 E. Index 7 reads as 0, and writes to it are dropped. Compute writes the ALU result to its destination, and the PC advances by 1.
- R5: Branch passes register x through the ALU. If the value is nonzero, the next PC is PC plus the signed immediate; otherwise it is PC+1.
- R6: Jump always sets the next PC to PC plus the signed immediate, and the sum wraps within 8 bits.
- R7: Store asserts mem_we in its own cycle, with mem_waddr set to immediate bits [4:0] and mem_wdata set to register x. No other opcode asserts mem_we.
- R8: Load drives mem_raddr with immediate bits [4:0] in its own cycle. mem_rdata shows the word one cycle later, and the destination register takes the word at the end of that later cycle. An instruction directly after a load therefore still reads the old register value.
- R9: Within one cycle, the ALU result written to its destination overrides returning load data for the same register. The next PC overrides both for the PC register. Zero always reads 0.
- R10: A GCD program that stores 4 and 6, loads them back and subtracts the smaller from the larger until they are equal leaves 2 at memory address 2. Loading that address then shows 2 on mem_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 8 | Instruction address, equal to the PC register |
| imem_data | input | 24 | Instruction word returned for imem_addr in the same cycle |
| mem_raddr | output | 5 | Data memory read address |
| mem_rdata | output | 8 | Data memory read data, one cycle after its address |
| mem_we | output | 1 | Data memory write strobe |
| mem_waddr | output | 5 | Data memory write address |
| mem_wdata | output | 8 | Data memory write data |

## Verification
The bench builds the block with its default values: 8-bit data, 32 memory words and seven registers. With those values the 8-bit wrap of add and subtract and of PC-relative targets can be reached with short operand-building sequences. Random trials build two signed operands with increment and negate chains, apply a random ALU code, and compare the stored result with a bench model. Directed programs cover the load shadow, the write-priority collisions, branches that are taken and not taken, and the full GCD loop.

// File: rtl/micro_core_pkg.sv
// Package: shared widths, field positions and code values for micro_core.
// Assumes the data width equals the instruction-address width (PC in bank).
package micro_core_pkg;

    localparam int DATA_W    = 8;
    localparam int DADDR_W   = 5;
    localparam int RIDX_W    = 3;
    localparam int OPC_W     = 3;
    localparam int FN_W      = 3;
    localparam int IMM_W     = 8;
    localparam int INSTR_W   = OPC_W + FN_W + 3 * RIDX_W + 1 + IMM_W;

    // Field base positions derived from the widths above.
    localparam int IMM_LSB   = 0;
    localparam int DST_LSB   = IMM_W + 1;
    localparam int Y_LSB     = DST_LSB + RIDX_W;
    localparam int X_LSB     = Y_LSB + RIDX_W;
    localparam int FN_LSB    = X_LSB + RIDX_W;
    localparam int OPC_LSB   = FN_LSB + FN_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_NOP     = 3'd0,
        OPC_COMPUTE = 3'd1,
        OPC_BRANCH  = 3'd2,
        OPC_JUMP    = 3'd3,
        OPC_LOAD    = 3'd4,
        OPC_STORE   = 3'd5
    } opcode_e;

    typedef enum logic [FN_W-1:0] {
        FN_ADD   = 3'd0,
        FN_SUB   = 3'd1,
        FN_INC   = 3'd2,
        FN_PASS  = 3'd3,
        FN_CMPGT = 3'd4
    } alu_fn_e;

    localparam logic [RIDX_W-1:0] RIDX_ZERO = 3'd0;
    localparam logic [RIDX_W-1:0] RIDX_PC   = 3'd1;

    // Decoded control bundle, one per cycle.
    typedef struct packed {
        logic [RIDX_W-1:0]  x_idx;
        logic [RIDX_W-1:0]  y_idx;
        logic [RIDX_W-1:0]  dst_idx;
        logic [FN_W-1:0]    fn;
        logic [RIDX_W-1:0]  ld_dst;
        logic [DADDR_W-1:0] rd_addr;
        logic               wr_en;
        logic [DADDR_W-1:0] wr_addr;
        logic               jmp_en;
        logic [IMM_W-1:0]   offset;
    } ctrl_t;

endpackage

// File: rtl/micro_core_decoder.sv
// Module: micro_core_decoder
// Turns one instruction word into a control bundle. Every field an
// instruction does not use is left at its default (Zero operands, Zero
// destination, pass function, no write, no jump). Purely combinational.
module micro_core_decoder
    import micro_core_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctrl_t              ctrl
);

    logic [OPC_W-1:0]   opc;
    logic [FN_W-1:0]    fn_f;
    logic [RIDX_W-1:0]  x_f;
    logic [RIDX_W-1:0]  y_f;
    logic [RIDX_W-1:0]  d_f;
    logic [IMM_W-1:0]   imm_f;
    logic               pad_unused;

    assign opc        = instr[OPC_LSB +: OPC_W];
    assign fn_f       = instr[FN_LSB  +: FN_W];
    assign x_f        = instr[X_LSB   +: RIDX_W];
    assign y_f        = instr[Y_LSB   +: RIDX_W];
    assign d_f        = instr[DST_LSB +: RIDX_W];
    assign imm_f      = instr[IMM_LSB +: IMM_W];
    assign pad_unused = instr[IMM_W];

    // Field defaults first, then the per-opcode overrides.
    always_comb begin
        ctrl         = '0;
        ctrl.fn      = FN_PASS;
        case (opc)
            OPC_COMPUTE: begin
                ctrl.x_idx   = x_f;
                ctrl.y_idx   = y_f;
                ctrl.dst_idx = d_f;
                ctrl.fn      = fn_f;
            end
            OPC_BRANCH: begin
                ctrl.x_idx  = x_f;
                ctrl.jmp_en = 1'b1;
                ctrl.offset = imm_f;
            end
            OPC_JUMP: begin
                ctrl.fn     = FN_INC;
                ctrl.jmp_en = 1'b1;
                ctrl.offset = imm_f;
            end
            OPC_LOAD: begin
                ctrl.ld_dst  = d_f;
                ctrl.rd_addr = imm_f[DADDR_W-1:0];
            end
            OPC_STORE: begin
                ctrl.x_idx   = x_f;
                ctrl.wr_en   = 1'b1;
                ctrl.wr_addr = imm_f[DADDR_W-1:0];
            end
            default: begin
                ctrl.fn = FN_PASS;
            end
        endcase
    end

endmodule

// File: rtl/micro_core_alu.sv
// Module: micro_core_alu
// Five-function signed ALU; codes outside the defined set pass x through.
// Add and subtract wrap at the data width. Combinational.
module micro_core_alu
    import micro_core_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [FN_W-1:0]     fn,
    input  logic signed [W-1:0] x,
    input  logic signed [W-1:0] y,
    output logic signed [W-1:0] res
);

    localparam logic signed [W-1:0] ONE = W'(1);

    // Select the result of the requested function.
    always_comb begin
        case (fn)
            FN_ADD:   res = x + y;
            FN_SUB:   res = x - y;
            FN_INC:   res = x + ONE;
            FN_CMPGT: res = (x > y) ? ONE : '0;
            default:  res = x;
        endcase
    end

endmodule

// File: rtl/micro_core_regbank.sv
// Module: micro_core_regbank
// Register bank with the PC at index 1. Holds the load destination for one
// cycle so that synchronous memory data lands in the right register.
// Per-register write priority: load data < ALU result < next PC; index 0
// is constant zero. Indices at or above NREGS read as zero.
module micro_core_regbank
    import micro_core_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int NREGS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RIDX_W-1:0] x_idx,
    input  logic [RIDX_W-1:0] y_idx,
    output logic [W-1:0]      x_val,
    output logic [W-1:0]      y_val,
    output logic [W-1:0]      pc_val,
    input  logic [RIDX_W-1:0] alu_dst,
    input  logic [W-1:0]      alu_val,
    input  logic [W-1:0]      next_pc,
    input  logic [RIDX_W-1:0] ld_dst,
    input  logic [W-1:0]      ld_data
);

    logic [W-1:0]      bank [NREGS];
    logic [RIDX_W-1:0] ld_dst_q;

    // Carry the load destination across the memory's read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) ld_dst_q <= RIDX_ZERO;
        else        ld_dst_q <= ld_dst;
    end

    genvar gi;
    generate
        for (gi = 0; gi < NREGS; gi++) begin : g_reg
            if (gi == 0) begin : g_zero
                assign bank[gi] = '0;
            end else if (gi == int'(RIDX_PC)) begin : g_pc
                // PC always takes the computed next address.
                always_ff @(posedge clk) begin
                    if (!rst_n) bank[gi] <= '0;
                    else        bank[gi] <= next_pc;
                end
            end else begin : g_gpr
                // ALU result wins over returning load data.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        bank[gi] <= '0;
                    else if (alu_dst == RIDX_W'(gi))
                        bank[gi] <= alu_val;
                    else if (ld_dst_q == RIDX_W'(gi))
                        bank[gi] <= ld_data;
                end
            end
        end
    endgenerate

    // Operand read ports with zero for unmapped indices.
    always_comb begin
        x_val = '0;
        y_val = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (x_idx == RIDX_W'(i)) x_val = bank[i];
            if (y_idx == RIDX_W'(i)) y_val = bank[i];
        end
    end

    assign pc_val = bank[RIDX_PC];

endmodule

// File: rtl/micro_core_dmem.sv
// Module: micro_core_dmem
// Data memory with one write port and a registered read port (data one
// cycle after the address). Old data is returned on a same-cycle read and
// write to one address. All words clear during reset.
module micro_core_dmem
    import micro_core_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [W-1:0] mem [DEPTH];

    // Storage update and registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata <= '0;
        end else begin
            if (we) mem[waddr] <= wdata;
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/micro_core.sv
// Module: micro_core (top)
// Single-cycle processor: fetch from an external combinational instruction
// store at the PC, decode, ALU, next-PC, bank update, internal data memory.
// Assumes software separates a load from the first reader of its register.
module micro_core
    import micro_core_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int NREGS  = 7,
    parameter int DDEPTH = 32,
    localparam int DAW   = $clog2(DDEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [W-1:0]       imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [DAW-1:0]     mem_raddr,
    output logic [W-1:0]       mem_rdata,
    output logic               mem_we,
    output logic [DAW-1:0]     mem_waddr,
    output logic [W-1:0]       mem_wdata
);

    localparam logic [W-1:0] PC_STEP = W'(1);

    ctrl_t        ctrl;
    logic [W-1:0] x_val;
    logic [W-1:0] y_val;
    logic [W-1:0] pc_val;
    logic [W-1:0] alu_res;
    logic [W-1:0] next_pc;
    logic         take_jump;

    micro_core_decoder u_dec (
        .instr (imem_data),
        .ctrl  (ctrl)
    );

    micro_core_regbank #(.W(W), .NREGS(NREGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_idx   (ctrl.x_idx),
        .y_idx   (ctrl.y_idx),
        .x_val   (x_val),
        .y_val   (y_val),
        .pc_val  (pc_val),
        .alu_dst (ctrl.dst_idx),
        .alu_val (alu_res),
        .next_pc (next_pc),
        .ld_dst  (ctrl.ld_dst),
        .ld_data (mem_rdata)
    );

    micro_core_alu #(.W(W)) u_alu (
        .fn  (ctrl.fn),
        .x   (x_val),
        .y   (y_val),
        .res (alu_res)
    );

    // Relative redirect when a jump-class instruction sees a nonzero ALU result.
    always_comb begin
        take_jump = ctrl.jmp_en && (alu_res != '0);
        next_pc   = pc_val + (take_jump ? W'(ctrl.offset) : PC_STEP);
    end

    micro_core_dmem #(.W(W), .DEPTH(DDEPTH)) u_dmem (
        .clk   (clk),
        .rst_n (rst_n),
        .raddr (mem_raddr),
        .rdata (mem_rdata),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata)
    );

    assign imem_addr = pc_val;
    assign mem_raddr = ctrl.rd_addr[DAW-1:0];
    assign mem_we    = ctrl.wr_en;
    assign mem_waddr = ctrl.wr_addr[DAW-1:0];
    assign mem_wdata = alu_res;

endmodule

// File: rtl/micro_core_checker.sv
// Module: micro_core_checker
// Port-level properties for micro_core, attached with bind below.
module micro_core_checker
    import micro_core_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         imem_addr,
    input logic [INSTR_W-1:0] imem_data,
    input logic [4:0]         mem_raddr,
    input logic [7:0]         mem_rdata,
    input logic               mem_we,
    input logic [4:0]         mem_waddr
);

    logic [OPC_W-1:0] opc;
    logic [IMM_W-1:0] imm;
    assign opc = imem_data[OPC_LSB +: OPC_W];
    assign imm = imem_data[IMM_LSB +: IMM_W];

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == 8'd0 && mem_rdata == 8'd0));

    assert_store_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (opc == OPC_STORE && mem_waddr == imm[4:0]));

    assert_nonstore_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_STORE) |-> !mem_we);

    assert_load_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_LOAD) |-> (mem_raddr == imm[4:0]));

    assert_jump_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OPC_JUMP) |=> (imem_addr == $past(imem_addr + imm)));

    assert_pc_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OPC_JUMP && opc != OPC_BRANCH) |=> (imem_addr == $past(imem_addr + 8'd1)));

endmodule

bind micro_core micro_core_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .imem_addr (imem_addr),
    .imem_data (imem_data),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr)
);

// File: tb/micro_core_tb_top.sv
// Bench for micro_core: directed programs plus seeded random ALU trials.
module micro_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [23:0] imem_data;
    logic [4:0]  mem_raddr;
    logic [7:0]  mem_rdata;
    logic        mem_we;
    logic [4:0]  mem_waddr;
    logic [7:0]  mem_wdata;

    logic [23:0] rom [256];
    logic [7:0]  tr_pc [256];
    logic [7:0]  tr_rd [256];
    int          ev_addr [64];
    int          ev_data [64];
    int          ev_cnt;
    int          p;
    int          errors = 0;
    int          checks = 0;
    bit          done = 0;

    always #5 clk = ~clk;

    assign imem_data = rom[imem_addr];

    micro_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata)
    );

    localparam int ZR = 0, PCR = 1, RA = 2, RB = 3, RC = 4, RD = 5;

    function automatic logic [23:0] enc(int op, int fn, int x, int y, int d, int imm);
        return {op[2:0], fn[2:0], x[2:0], y[2:0], d[2:0], 1'b0, imm[7:0]};
    endfunction

    function automatic int alu_model(int fn, int a, int b);
        logic signed [7:0] r;
        case (fn)
            0: r = 8'(a + b);
            1: r = 8'(a - b);
            2: r = 8'(a + 1);
            4: r = (a > b) ? 8'sd1 : 8'sd0;
            default: r = 8'(a);
        endcase
        return int'(r);
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = enc(3, 0, 0, 0, 0, 0);
        p = 0;
    endtask

    task automatic put(logic [23:0] w);
        rom[p] = w;
        p++;
    endtask

    // Build register r = v using increment chains and a negate.
    task automatic build(int r, int v);
        int m;
        m = (v < 0) ? -v : v;
        for (int i = 0; i < m; i++) put(enc(1, 2, (i == 0) ? ZR : r, ZR, r, 0));
        if (v < 0) put(enc(1, 1, ZR, r, r, 0));
    endtask

    // Reset, run n cycles, record PC, read data and stores per cycle.
    task automatic run(int n, bit check_reset);
        rst_n = 1'b0;
        ev_cnt = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        if (check_reset) begin
            chk("R1 reset pc", int'(imem_addr), 0);
            chk("R1 reset rdata", int'(mem_rdata), 0);
        end
        rst_n = 1'b1;
        for (int k = 0; k < n; k++) begin
            tr_pc[k] = imem_addr;
            tr_rd[k] = mem_rdata;
            if (mem_we && ev_cnt < 64) begin
                ev_addr[ev_cnt] = int'(mem_waddr);
                ev_data[ev_cnt] = int'($signed(mem_wdata));
                ev_cnt++;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int gcd_at;
        void'($urandom(32'h5eed_1234));

        // ---- Load latency, priority, Zero, branches (R2 R4 R5 R7 R8 R9)
        clear_rom();
        build(RA, 7);                          // 0..6
        put(enc(5, 0, RA, 0, 0, 5));           // 7  store A@5
        put(enc(4, 0, 0, 0, RB, 5));           // 8  load B
        put(enc(5, 0, RB, 0, 0, 6));           // 9  store B (old)
        put(enc(5, 0, RB, 0, 0, 7));           // 10 store B (new)
        put(enc(5, 0, RA, 0, 0, 3));           // 11 store A@3
        put(enc(4, 0, 0, 0, RA, 3));           // 12 load A
        put(enc(1, 2, ZR, ZR, RA, 0));         // 13 A=1 collides with load
        put(enc(5, 0, RA, 0, 0, 4));           // 14 store A
        put(enc(1, 2, ZR, ZR, ZR, 0));         // 15 write Zero
        put(enc(5, 0, ZR, 0, 0, 8));           // 16 store Zero
        put(enc(1, 2, RA, ZR, PCR, 0));        // 17 ALU to PC
        put(enc(7, 0, RA, 0, RA, 9));          // 18 undefined opcode
        put(enc(2, 0, ZR, 0, 0, 5));           // 19 branch not taken
        put(enc(1, 1, ZR, RA, RD, 0));         // 20 D=-1
        put(enc(2, 0, RD, 0, 0, 3));           // 21 branch taken -> 24
        put(enc(5, 0, RA, 0, 0, 9));           // 22 skipped
        put(enc(5, 0, RA, 0, 0, 9));           // 23 skipped
        run(30, 1'b0);
        chk("R7 store count", ev_cnt, 6);
        chk("R7 addr", ev_addr[0], 5);
        chk("R7 data", ev_data[0], 7);
        chk("R8 next reader sees old value", ev_data[1], 0);
        chk("R8 loaded value after gap", ev_data[2], 7);
        chk("R8 rdata one cycle after load", int'(tr_rd[9]), 7);
        chk("R9 ALU beats load data", ev_data[4], 1);
        chk("R9 Zero stays 0", ev_data[5], 0);
        chk("R9 next PC beats ALU dest", int'(tr_pc[18]), 18);
        chk("R2 undefined opcode steps", int'(tr_pc[19]), 19);
        chk("R5 branch not taken", int'(tr_pc[20]), 20);
        chk("R5 branch taken", int'(tr_pc[22]), 24);
        chk("R6 jump offset 0 holds", int'(tr_pc[25]), 24);

        // ---- Memory cleared by reset (R1)
        clear_rom();
        put(enc(4, 0, 0, 0, RC, 5));
        run(4, 1'b1);
        chk("R1 memory cleared", int'(tr_rd[1]), 0);

        // ---- GCD program (R10, R5, R6)
        clear_rom();
        build(RA, 4);                          // 0..3
        put(enc(5, 0, RA, 0, 0, 0));           // 4
        build(RA, 6);                          // 5..10
        put(enc(5, 0, RA, 0, 0, 1));           // 11
        put(enc(4, 0, 0, 0, RA, 0));           // 12
        put(enc(4, 0, 0, 0, RB, 1));           // 13
        put(enc(0, 0, 0, 0, 0, 0));            // 14
        put(enc(1, 4, RA, RB, RC, 0));         // 15
        put(enc(2, 0, RC, 0, 0, 4));           // 16
        put(enc(1, 4, RB, RA, RC, 0));         // 17
        put(enc(2, 0, RC, 0, 0, 4));           // 18
        put(enc(3, 0, 0, 0, 0, 5));            // 19
        put(enc(1, 1, RA, RB, RA, 0));         // 20
        put(enc(3, 0, 0, 0, 0, 8'hFA));        // 21 -6
        put(enc(1, 1, RB, RA, RB, 0));         // 22
        put(enc(3, 0, 0, 0, 0, 8'hF8));        // 23 -8
        put(enc(5, 0, RA, 0, 0, 2));           // 24
        put(enc(4, 0, 0, 0, RC, 2));           // 25
        run(120, 1'b0);
        gcd_at = -1;
        for (int k = 0; k < 120; k++) if (gcd_at < 0 && tr_pc[k] == 8'd26) gcd_at = k;
        chk("R10 reached end", (gcd_at > 0) ? 1 : 0, 1);
        if (gcd_at > 0) chk("R10 readback of address 2", int'(tr_rd[gcd_at]), 2);
        chk("R10 stored result addr", ev_addr[ev_cnt-1], 2);
        chk("R10 stored result", ev_data[ev_cnt-1], 2);

        // ---- ALU trials: directed corners then seeded random (R3 R4)
        for (int t = 0; t < 14; t++) begin
            int a, b, fn;
            if (t == 0) begin a = 100; b = 100; fn = 0; end
            else if (t == 1) begin a = -3; b = 2; fn = 4; end
            else if (t == 2) begin a = -100; b = 100; fn = 1; end
            else begin
                a = int'($urandom_range(30)) - 15;
                b = int'($urandom_range(30)) - 15;
                fn = int'($urandom_range(7));
            end
            clear_rom();
            build(RA, a);
            build(RB, b);
            put(enc(1, fn, RA, RB, RC, 0));
            put(enc(5, 0, RC, 0, 0, 0));
            put(enc(5, 0, RA, 0, 0, 1));
            put(enc(5, 0, RB, 0, 0, 2));
            run(p + 3, 1'b0);
            chk("R4 store events", ev_cnt, 3);
            chk("R3 alu result", ev_data[0], alu_model(fn, a, b));
            chk("R4 operand a", ev_data[1], a);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule